// File: doc/BRIEF.md
# Low-Power SAR ADC Conversion Controller

This block sequences a 10-bit successive-approximation converter and applies the sleep and reset rules of a microcontroller-style ADC. Software reaches six byte-wide registers through a small register port: two control registers, the high and low result bytes, an interrupt flag register and an interrupt enable register. Setting the start bit begins a conversion. The controller then presents a trial code to an external DAC and, one conversion clock at a time, reads back an external comparator. When the conversion ends it loads the result, justified left or right, clears the start bit and raises the interrupt flag.

The conversion clock is either the system clock divided by one of three ratios or an internal RC tick. The selected clock decides what a sleep request does. With the RC clock the conversion runs on through sleep. When it completes, the controller either pulses a wake-up output or powers the converter down. With any divided clock, sleep aborts the conversion and powers the converter down. In both power-down cases the enable bit still reads as set. When the RC clock is selected, a start waits one instruction time before the conversion begins, so that the core can enter sleep first.

Top module: `sarSleepAdc`

## Requirements
- R1: After reset, both control registers read 0x00 (port configuration 4'b0000, all inputs analog), the flag and enable registers read 0x00, and converterOn, intFlag and wakeUp are 0.
- R2: A control-0 write with the start bit (bit 1) set is ignored unless the enable bit (bit 0) is already 1 and is also 1 in the written data. An ignored start leaves the start bit at 0 and sets no flag.
- R3: The clock-select field is control-0 bits [3:2]: 00 divides by 2, 01 by 8, 10 by 32, and 11 selects the RC tick. A divided-clock conversion takes 12 conversion clocks: one settle period and 10 MSB-first bit trials, with the result loaded on the 12th. The flag rises and the start bit clears exactly 12×ratio system clocks after the start write edge.
- R4: The format bit is control-1 bit 0. When it is 1 the high byte (address 2) holds {6'b0, result[9:8]} and the low byte (address 3) holds result[7:0]. When it is 0 the high byte holds result[9:2] and the low byte holds {result[1:0], 6'b0}.
- R5: The interrupt flag is bit 6 of the flag register (address 4). Every completed conversion sets it, and it stays set until software writes that bit to 0.
- R6: The interrupt enable is bit 6 of address 5. irqReq equals flag AND enable AND globalIntEn.
- R7: A sleep request while a divided clock is selected aborts any conversion on the next edge. The start bit clears, converterOn drops to 0, the enable bit still reads 1, no flag is set and the result bytes are unchanged.
- R8: With the RC clock, a conversion starts only after 4 system clocks, and RC ticks in that window are ignored. The conversion then continues through sleep. If the enable is set, completion sets the flag and pulses wakeUp for exactly one cycle, and the converter stays on.
- R9: An RC conversion that completes during sleep with the enable clear sets the flag, produces no wakeUp, and powers the converter down (converterOn 0) while the enable bit still reads 1.
- R10: Writing the enable bit to 0 during a conversion aborts it. The start bit clears, no flag is set and the result bytes are unchanged.
- R11: converterOn returns to 1 in the cycle after sleepReq falls, provided the enable bit is 1.
- R12: A reset during a conversion aborts it and clears the control, flag and enable registers, but leaves the result bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register select: 0 control-0, 1 control-1, 2 high result, 3 low result, 4 flag, 5 enable |
| regWrEn | input | 1 | Write strobe, sampled on the rising edge |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| sleepReq | input | 1 | High while the core is asleep |
| rcTick | input | 1 | One-cycle pulse per internal RC conversion clock |
| cmpIn | input | 1 | Comparator result: 1 when the input is at or above the DAC code |
| globalIntEn | input | 1 | Global interrupt enable from the core |
| dacCode | output | 10 | Current trial code for the DAC |
| chanSel | output | 3 | Channel field, control-0 bits [6:4] |
| portCfg | output | 4 | Port configuration field, control-1 bits [7:4] |
| converterOn | output | 1 | Converter powered (enable set and not powered down) |
| intFlag | output | 1 | ADC interrupt flag |
| irqReq | output | 1 | Interrupt request towards the core |
| wakeUp | output | 1 | One-cycle wake pulse at completion during sleep |

## Verification
A divided-clock conversion finishes on the edge 12×ratio clocks after the start write. The bench therefore checks the flag one clock before that edge, where it must still be 0, and again just after it. RC conversions are timed by the bench's own tick pulses. Two ticks fall inside the 4-clock start delay and must be ignored, so the flag is checked after the 11th counted tick and again after the 12th. Aborts from sleep and from clearing the enable bit take effect on the next edge and are sampled one clock later, and the bench then waits past the whole conversion time to confirm that no flag and no new result appear. Wake pulses are counted on every edge.

// File: rtl/sarSleepAdcPkg.sv
package sarSleepAdcPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_CONV  = 2'd2
  } convState_t;

  typedef struct packed {
    logic clear;
    logic decide;
    logic load;
  } sarStrobe_t;

  localparam logic [1:0] CLK_RC     = 2'b11;
  localparam logic [2:0] ADDR_CTRLA = 3'd0;
  localparam logic [2:0] ADDR_CTRLB = 3'd1;
  localparam logic [2:0] ADDR_RESHI = 3'd2;
  localparam logic [2:0] ADDR_RESLO = 3'd3;
  localparam logic [2:0] ADDR_FLAG  = 3'd4;
  localparam logic [2:0] ADDR_IEN   = 3'd5;

endpackage

// File: rtl/sarSleepAdcCtrl.sv
module sarSleepAdcCtrl
  import sarSleepAdcPkg::*;
#(
  parameter int RES_BITS     = 10,
  parameter int DIV_A        = 2,
  parameter int DIV_B        = 8,
  parameter int DIV_C        = 32,
  parameter int INSTR_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       sleepReq,
  input  logic       rcTick,
  output sarStrobe_t strobe,
  output logic [7:0] ctrlAVal,
  output logic [7:0] ctrlBVal,
  output logic       fmtBit,
  output logic [2:0] chanSel,
  output logic [3:0] portCfg,
  output logic       converterOn,
  output logic       intFlag,
  output logic       intEn,
  output logic       wakeUp
);

  localparam int DIVW  = $clog2(DIV_C + 1);
  localparam int STEPW = $clog2(RES_BITS + 2);
  localparam int DLYW  = $clog2(INSTR_CYCLES + 1);
  localparam logic [STEPW-1:0] LAST_STEP = STEPW'(RES_BITS + 1);
  localparam logic [STEPW-1:0] BIT_STEPS = STEPW'(RES_BITS);
  localparam logic [DLYW-1:0]  DLY_LAST  = DLYW'(INSTR_CYCLES - 1);

  convState_t state;
  logic adon, goBit, powerDown;
  logic [1:0] clkSel;
  logic [DIVW-1:0] divCnt, divLimit;
  logic [STEPW-1:0] stepCnt;
  logic [DLYW-1:0] dlyCnt;

  logic wrA, wrB, wrFlag, wrIen;
  logic isRc, tick, busy, startOk, abort, finishOk;

  assign wrA    = regWrEn && (regAddr == ADDR_CTRLA);
  assign wrB    = regWrEn && (regAddr == ADDR_CTRLB);
  assign wrFlag = regWrEn && (regAddr == ADDR_FLAG);
  assign wrIen  = regWrEn && (regAddr == ADDR_IEN);

  assign isRc = (clkSel == CLK_RC);

  always_comb begin
    case (clkSel)
      2'b00:   divLimit = DIVW'(DIV_A - 1);
      2'b01:   divLimit = DIVW'(DIV_B - 1);
      default: divLimit = DIVW'(DIV_C - 1);
    endcase
  end

  assign tick     = isRc ? rcTick : (divCnt == divLimit);
  assign busy     = (state != ST_IDLE);
  assign startOk  = wrA && regWrData[1] && regWrData[0] && adon && !busy && !powerDown;
  assign abort    = busy && ((wrA && !regWrData[0]) || (sleepReq && !isRc));
  assign finishOk = (state == ST_CONV) && tick && (stepCnt == LAST_STEP) && !abort;

  always_comb begin
    strobe.clear  = startOk;
    strobe.decide = (state == ST_CONV) && tick && !abort &&
                    (stepCnt != '0) && (stepCnt <= BIT_STEPS);
    strobe.load   = finishOk;
  end

  // register fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adon    <= 1'b0;
      clkSel  <= 2'b00;
      chanSel <= 3'b000;
      fmtBit  <= 1'b0;
      portCfg <= 4'b0000;
      intEn   <= 1'b0;
      intFlag <= 1'b0;
      goBit   <= 1'b0;
    end else begin
      if (wrA) begin
        adon    <= regWrData[0];
        clkSel  <= regWrData[3:2];
        chanSel <= regWrData[6:4];
      end
      if (wrB) begin
        fmtBit  <= regWrData[0];
        portCfg <= regWrData[7:4];
      end
      if (wrIen) intEn <= regWrData[6];
      if (finishOk)    intFlag <= 1'b1;
      else if (wrFlag) intFlag <= regWrData[6];
      if (startOk)                goBit <= 1'b1;
      else if (abort || finishOk) goBit <= 1'b0;
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      stepCnt <= '0;
      dlyCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startOk) begin
            state   <= (regWrData[3:2] == CLK_RC) ? ST_DELAY : ST_CONV;
            divCnt  <= '0;
            stepCnt <= '0;
            dlyCnt  <= '0;
          end
        end
        ST_DELAY: begin
          if (abort) state <= ST_IDLE;
          else if (dlyCnt == DLY_LAST) begin
            state  <= ST_CONV;
            divCnt <= '0;
          end else dlyCnt <= dlyCnt + 1'b1;
        end
        ST_CONV: begin
          if (abort) state <= ST_IDLE;
          else if (tick) begin
            divCnt <= '0;
            if (stepCnt == LAST_STEP) state <= ST_IDLE;
            else stepCnt <= stepCnt + 1'b1;
          end else divCnt <= divCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // sleep handling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powerDown <= 1'b0;
      wakeUp    <= 1'b0;
    end else begin
      wakeUp <= finishOk && sleepReq && intEn;
      if (!sleepReq) powerDown <= 1'b0;
      else if (!isRc || (finishOk && !intEn)) powerDown <= 1'b1;
    end
  end

  assign converterOn = adon && !powerDown;
  assign ctrlAVal    = {1'b0, chanSel, clkSel, goBit, adon};
  assign ctrlBVal    = {portCfg, 3'b000, fmtBit};

  // R2: start only with the enable already set
  p_go_needs_adon_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(goBit) |-> (adon && $past(adon)));

  // R7: divided-clock sleep kills a running conversion
  p_sleep_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && !isRc && goBit) |=> !goBit);

  // R5: flag only drops through a software write
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && !wrFlag) |=> intFlag);

  // R8: wake only with the flag raised and enable set
  p_wake_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp |-> (intFlag && intEn));

  // R11: power-down released once sleep ends
  p_pd_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    !sleepReq |=> !powerDown);

endmodule

// File: rtl/sarSleepAdcDatapath.sv
module sarSleepAdcDatapath
  import sarSleepAdcPkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  sarStrobe_t          strobe,
  input  logic                cmpIn,
  input  logic                fmtBit,
  output logic [RES_BITS-1:0] dacCode,
  output logic [7:0]          resHi,
  output logic [7:0]          resLo
);

  localparam int PADW = 16 - RES_BITS;
  localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] sarReg, trialMask;
  logic [15:0] rightJust, leftJust;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg    <= '0;
      trialMask <= '0;
    end else if (strobe.clear) begin
      sarReg    <= '0;
      trialMask <= TOP_BIT;
    end else if (strobe.decide) begin
      if (cmpIn) sarReg <= sarReg | trialMask;
      trialMask <= trialMask >> 1;
    end
  end

  assign dacCode   = sarReg | trialMask;
  assign rightJust = 16'(sarReg);
  assign leftJust  = 16'(sarReg) << PADW;

  // result bytes keep their contents through reset
  always_ff @(posedge clk) begin
    if (strobe.load) begin
      resHi <= fmtBit ? rightJust[15:8] : leftJust[15:8];
      resLo <= fmtBit ? rightJust[7:0]  : leftJust[7:0];
    end
  end

  // R3: at most one trial bit outstanding
  p_one_trial_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trialMask));

  // R4: zero padding in the justified bytes
  p_right_pad_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && fmtBit) |=> ((resHi >> (RES_BITS - 8)) == 8'd0));

  p_left_pad_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !fmtBit) |=> ((resLo & 8'((1 << PADW) - 1)) == 8'd0));

  // R10: results change only on a load
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(resHi) && $stable(resLo)));

endmodule

// File: rtl/sarSleepAdc.sv
module sarSleepAdc
  import sarSleepAdcPkg::*;
#(
  parameter int RES_BITS     = 10,
  parameter int DIV_A        = 2,
  parameter int DIV_B        = 8,
  parameter int DIV_C        = 32,
  parameter int INSTR_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          regAddr,
  input  logic                regWrEn,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  input  logic                sleepReq,
  input  logic                rcTick,
  input  logic                cmpIn,
  input  logic                globalIntEn,
  output logic [RES_BITS-1:0] dacCode,
  output logic [2:0]          chanSel,
  output logic [3:0]          portCfg,
  output logic                converterOn,
  output logic                intFlag,
  output logic                irqReq,
  output logic                wakeUp
);

  sarStrobe_t strobe;
  logic [7:0] ctrlAVal, ctrlBVal, resHi, resLo;
  logic fmtBit, intEn;

  sarSleepAdcCtrl #(
    .RES_BITS(RES_BITS), .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C),
    .INSTR_CYCLES(INSTR_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .sleepReq(sleepReq), .rcTick(rcTick),
    .strobe(strobe), .ctrlAVal(ctrlAVal), .ctrlBVal(ctrlBVal),
    .fmtBit(fmtBit), .chanSel(chanSel), .portCfg(portCfg),
    .converterOn(converterOn), .intFlag(intFlag), .intEn(intEn),
    .wakeUp(wakeUp)
  );

  sarSleepAdcDatapath #(.RES_BITS(RES_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpIn(cmpIn),
    .fmtBit(fmtBit), .dacCode(dacCode), .resHi(resHi), .resLo(resLo)
  );

  always_comb begin
    case (regAddr)
      ADDR_CTRLA: regRdData = ctrlAVal;
      ADDR_CTRLB: regRdData = ctrlBVal;
      ADDR_RESHI: regRdData = resHi;
      ADDR_RESLO: regRdData = resLo;
      ADDR_FLAG:  regRdData = {1'b0, intFlag, 6'b0};
      ADDR_IEN:   regRdData = {1'b0, intEn, 6'b0};
      default:    regRdData = 8'h00;
    endcase
  end

  assign irqReq = intFlag && intEn && globalIntEn;

endmodule

// File: tb/sarSleepAdc_tb.sv
`timescale 1ns/1ps
module sarSleepAdc_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic sleepReq = 1'b0;
  logic rcTick = 1'b0;
  logic cmpIn;
  logic globalIntEn = 1'b0;
  logic [9:0] dacCode;
  logic [2:0] chanSel;
  logic [3:0] portCfg;
  logic converterOn, intFlag, irqReq, wakeUp;

  logic [9:0] analogVal = 10'd0;
  int checks = 0;
  int errors = 0;
  int wakeCnt = 0;
  logic [7:0] rdv;

  always #5 clk = ~clk;

  // comparator and DAC stub
  assign cmpIn = (analogVal >= dacCode);

  always @(posedge clk) if (wakeUp) wakeCnt <= wakeCnt + 1;

  sarSleepAdc dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sleepReq(sleepReq),
    .rcTick(rcTick), .cmpIn(cmpIn), .globalIntEn(globalIntEn),
    .dacCode(dacCode), .chanSel(chanSel), .portCfg(portCfg),
    .converterOn(converterOn), .intFlag(intFlag), .irqReq(irqReq),
    .wakeUp(wakeUp)
  );

  // analog, format, expected high byte, expected low byte
  localparam logic [26:0] VEC [7] = '{
    {10'h000, 1'b1, 8'h00, 8'h00},
    {10'h3FF, 1'b1, 8'h03, 8'hFF},
    {10'h3FF, 1'b0, 8'hFF, 8'hC0},
    {10'h2A5, 1'b1, 8'h02, 8'hA5},
    {10'h2A5, 1'b0, 8'hA9, 8'h40},
    {10'h155, 1'b0, 8'h55, 8'h40},
    {10'h001, 1'b1, 8'h00, 8'h01}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseTick();
    @(negedge clk); rcTick = 1'b1;
    @(negedge clk); rcTick = 1'b0;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    waitNeg(3);
    rstN = 1'b1;
    // R1 reset state
    rd(3'd0, rdv); chk("R1 ctrl0", rdv, 8'h00);
    rd(3'd1, rdv); chk("R1 ctrl1", rdv, 8'h00);
    rd(3'd4, rdv); chk("R1 flag", rdv, 8'h00);
    rd(3'd5, rdv); chk("R1 enable", rdv, 8'h00);
    chk("R1 converterOn", converterOn, 1'b0);
    chk("R1 portCfg", portCfg, 4'h0);
    chk("R1 wakeUp", wakeUp, 1'b0);

    // R2 start without enable ignored
    wr(3'd0, 8'h02);
    rd(3'd0, rdv); chk("R2 go ignored", rdv, 8'h00);
    waitNeg(30);
    chk("R2 no flag", intFlag, 1'b0);

    wr(3'd0, 8'h01);
    chk("R11 on after enable", converterOn, 1'b1);

    // R3 R4 R5 vector walk, divide by 2
    for (int k = 0; k < 7; k++) begin
      analogVal = VEC[k][26:17];
      wr(3'd1, {7'd0, VEC[k][16]});
      wr(3'd0, 8'h03);
      waitNeg(23);
      chk("R3 flag before 12 ticks", intFlag, 1'b0);
      waitNeg(1);
      chk("R3 flag at 12 ticks", intFlag, 1'b1);
      rd(3'd0, rdv); chk("R3 go cleared", rdv, 8'h01);
      rd(3'd2, rdv); chk("R4 high byte", rdv, VEC[k][15:8]);
      rd(3'd3, rdv); chk("R4 low byte", rdv, VEC[k][7:0]);
      waitNeg(5);
      chk("R5 flag sticky", intFlag, 1'b1);
      wr(3'd4, 8'h00);
      chk("R5 flag cleared", intFlag, 1'b0);
    end

    // R3 divide by 8
    wr(3'd0, 8'h05);
    analogVal = 10'h1C3;
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h07);
    waitNeg(95);
    chk("R3 div8 before", intFlag, 1'b0);
    waitNeg(1);
    chk("R3 div8 done", intFlag, 1'b1);
    rd(3'd2, rdv); chk("R3 div8 high", rdv, 8'h01);
    rd(3'd3, rdv); chk("R3 div8 low", rdv, 8'hC3);
    wr(3'd4, 8'h00);

    // R6 interrupt request gating
    globalIntEn = 1'b1;
    wr(3'd5, 8'h40);
    chk("R6 no flag", irqReq, 1'b0);
    wr(3'd4, 8'h40);
    chk("R6 all set", irqReq, 1'b1);
    globalIntEn = 1'b0; #1;
    chk("R6 global off", irqReq, 1'b0);
    globalIntEn = 1'b1;
    wr(3'd5, 8'h00);
    chk("R6 enable off", irqReq, 1'b0);
    wr(3'd4, 8'h00);

    // R7 divided-clock sleep abort
    analogVal = 10'h0AA;
    wr(3'd0, 8'h07);
    waitNeg(20);
    sleepReq = 1'b1;
    waitNeg(1);
    chk("R7 powered down", converterOn, 1'b0);
    rd(3'd0, rdv); chk("R7 enable kept, go cleared", rdv, 8'h05);
    waitNeg(120);
    chk("R7 no flag", intFlag, 1'b0);
    rd(3'd2, rdv); chk("R7 high kept", rdv, 8'h01);
    rd(3'd3, rdv); chk("R7 low kept", rdv, 8'hC3);
    sleepReq = 1'b0;
    waitNeg(1);
    chk("R11 power back", converterOn, 1'b1);

    // R10 abort by clearing enable
    wr(3'd0, 8'h01);
    analogVal = 10'h3AB;
    wr(3'd0, 8'h03);
    waitNeg(10);
    wr(3'd0, 8'h00);
    waitNeg(40);
    chk("R10 no flag", intFlag, 1'b0);
    rd(3'd0, rdv); chk("R10 go cleared", rdv, 8'h00);
    rd(3'd2, rdv); chk("R10 high kept", rdv, 8'h01);
    rd(3'd3, rdv); chk("R10 low kept", rdv, 8'hC3);

    // R8 RC clock, sleep with enable set
    wr(3'd0, 8'h0D);
    wr(3'd5, 8'h40);
    wr(3'd1, 8'h01);
    analogVal = 10'h2F0;
    wakeCnt = 0;
    wr(3'd0, 8'h0F);
    sleepReq = 1'b1;
    pulseTick();
    pulseTick();
    for (int t = 0; t < 11; t++) pulseTick();
    chk("R8 start delay ignores ticks", intFlag, 1'b0);
    pulseTick();
    chk("R8 done in sleep", intFlag, 1'b1);
    waitNeg(2);
    chk("R8 single wake pulse", wakeCnt, 1);
    chk("R8 stays on", converterOn, 1'b1);
    rd(3'd2, rdv); chk("R8 high", rdv, 8'h02);
    rd(3'd3, rdv); chk("R8 low", rdv, 8'hF0);
    sleepReq = 1'b0;
    wr(3'd4, 8'h00);

    // R9 RC clock, sleep with enable clear
    wr(3'd5, 8'h00);
    wr(3'd1, 8'h00);
    analogVal = 10'h155;
    wakeCnt = 0;
    wr(3'd0, 8'h0F);
    sleepReq = 1'b1;
    waitNeg(4);
    for (int t = 0; t < 12; t++) pulseTick();
    chk("R9 flag", intFlag, 1'b1);
    chk("R9 powered down", converterOn, 1'b0);
    waitNeg(2);
    chk("R9 no wake", wakeCnt, 0);
    rd(3'd0, rdv); chk("R9 enable kept", rdv, 8'h0D);
    rd(3'd2, rdv); chk("R9 high", rdv, 8'h55);
    rd(3'd3, rdv); chk("R9 low", rdv, 8'h40);
    sleepReq = 1'b0;
    waitNeg(1);
    chk("R11 power back after RC", converterOn, 1'b1);
    wr(3'd4, 8'h00);

    // R12 reset mid conversion
    wr(3'd1, 8'hA1);
    wr(3'd0, 8'h09);
    analogVal = 10'h3FF;
    wr(3'd0, 8'h0B);
    waitNeg(50);
    rstN = 1'b0;
    waitNeg(2);
    rstN = 1'b1;
    waitNeg(1);
    rd(3'd0, rdv); chk("R12 ctrl0 cleared", rdv, 8'h00);
    rd(3'd1, rdv); chk("R12 ctrl1 cleared", rdv, 8'h00);
    chk("R12 portCfg analog", portCfg, 4'h0);
    rd(3'd4, rdv); chk("R12 flag cleared", rdv, 8'h00);
    chk("R12 off", converterOn, 1'b0);
    rd(3'd2, rdv); chk("R12 high kept", rdv, 8'h55);
    rd(3'd3, rdv); chk("R12 low kept", rdv, 8'h40);

    finishRun();
  end

endmodule